// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block lets a 16-bit data-side port read and modify a 24-bit-wide program memory. Each access carries an 8-bit page value and a 16-bit effective address; the two are joined into a 24-bit byte address. Bit 0 of the effective address selects a byte. The remaining bits select a program word. Low accesses reach bits 15:0 of a word and high accesses reach bits 23:16. Each kind can move a whole word or a single byte.

Table writes never touch the array directly. They fill a row latch that holds one row of program words. A row commit then merges the whole latch into the addressed row, and a word commit merges one latch entry into one array word. Programming can only clear bits. A page erase sets every word of a page back to all ones. Commits and erases run in a sequencer with the states IDLE, ROW_PROG, WORD_PROG and PAGE_ERASE. IDLE moves to the matching state when a commit or erase is accepted. Each working state returns to IDLE after a fixed OP_CYCLES cycles and raises a one-cycle done pulse. The most significant address bit selects configuration space, which this block neither stores nor modifies.

Top module: `pm_table_unit`

## Requirements
- R1: The program word index is ({page, ea} >> 1) reduced modulo MEM_WORDS, and ea bit 0 is the byte lane. Two addresses that differ only above the index bits therefore reach the same word.
- R2: Command codes on cmd_op are 1 = low read, 2 = high read, 3 = low write, 4 = high write, 5 = row commit, 6 = word commit, 7 = page erase, 0 = none. In word mode (byte_mode=0), a low read accepted at a clock edge places bits 15:0 of the word on rdata from that edge onward.
- R3: A low read in byte mode returns bits 7:0 for lane 0 and bits 15:8 for lane 1 on rdata[7:0], with rdata[15:8] = 0.
- R4: A high read returns {8'h00, bits 23:16} in word mode and in byte mode lane 0. In byte mode lane 1 it returns 16'h0000.
- R5: Table writes change only the row latch entry at index (word index mod ROW_WORDS), and the array is unchanged until a commit. A low word write stores wdata[15:0]. A low byte write stores wdata[7:0] into the selected lane. A high write in word mode or lane 0 stores wdata[7:0] into bits 23:16. A high byte write to lane 1 is ignored.
- R6: A row commit replaces each of the ROW_WORDS words in the row that holds the address with the old word ANDed with its latch entry.
- R7: A word commit changes only the addressed word, to the old word ANDed with the latch entry at its row index.
- R8: A page erase sets the PAGE_WORDS words of the addressed page to 24'hFFFFFF and leaves other pages unchanged.
- R9: busy is high for exactly OP_CYCLES cycles, starting with the cycle after a commit or erase is accepted. done is high only for the single cycle after busy falls.
- R10: Every command that arrives while busy is high is ignored. It starts no operation, changes neither rdata nor the latch, and modifies no array word.
- R11: When page bit 7 is 1 (configuration space), reads return 0, latch writes are ignored, and commits and erases are ignored without raising busy.
- R12: The row latch holds all ones after reset and again after each completed row or word commit.
- R13: After reset, busy, done and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| page | input | 8 | Page value, upper address byte |
| ea | input | 16 | Effective address; bit 0 is the byte lane |
| wdata | input | 16 | Table write data |
| rdata | output | 16 | Table read result, held until the next accepted read |
| busy | output | 1 | Commit or erase in progress |
| done | output | 1 | One-cycle pulse after an operation ends |

## Verification
A read result is due one edge after the command is accepted, so it is sampled on the falling edge that follows that edge. busy rises in the cycle after a commit or erase is accepted and stays high for OP_CYCLES sampled cycles. done is due in the first sampled cycle in which busy is low again. The bench's reference model updates right after each rising edge using the inputs sampled there. Every falling edge compares busy, done and rdata against the model. The array and latch effects of commits and erases are checked later, through reads that follow the operation.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_RD_LO     = 3'd1,
        OP_RD_HI     = 3'd2,
        OP_WR_LO     = 3'd3,
        OP_WR_HI     = 3'd4,
        OP_PROG_ROW  = 3'd5,
        OP_PROG_WORD = 3'd6,
        OP_ERASE     = 3'd7
    } pmt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ROW_PROG   = 2'd1,
        ST_WORD_PROG  = 2'd2,
        ST_PAGE_ERASE = 2'd3
    } pmt_state_e;

    localparam int PMT_WORD_W = 24;
    localparam int PMT_DATA_W = 16;

endpackage

// File: rtl/pmt_addr_gen.sv
module pmt_addr_gen #(
    parameter int PAGE_W = 8,
    parameter int EA_W   = 16,
    parameter int IDX_W  = 11
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [EA_W-1:0]   ea,
    output logic [IDX_W-1:0]  idx,
    output logic              lane,
    output logic              cfg_space
);
    localparam int FULL_W = PAGE_W + EA_W;

    logic [FULL_W-1:0] full_addr;

    always_comb begin
        full_addr = {page, ea};
        lane      = full_addr[0];
        cfg_space = full_addr[FULL_W-1];
        idx       = IDX_W'(full_addr >> 1);
    end

endmodule

// File: rtl/pmt_row_latch.sv
module pmt_row_latch #(
    parameter int ROW_WORDS = 64,
    parameter int WORD_W    = 24,
    localparam int RIDX_W   = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic              byte_mode,
    input  logic              lane,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [15:0]       wdata,
    input  logic              clear,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] ent_q [ROW_WORDS];
    logic [WORD_W-1:0] merged;

    always_comb begin
        merged = ent_q[wr_idx];
        if (!wr_hi) begin
            if (!byte_mode)  merged[15:0]  = wdata;
            else if (!lane)  merged[7:0]   = wdata[7:0];
            else             merged[15:8]  = wdata[7:0];
        end else if (!byte_mode || !lane) begin
            merged[23:16] = wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_WORDS; i++) ent_q[i] <= '1;
        end else if (clear) begin
            for (int i = 0; i < ROW_WORDS; i++) ent_q[i] <= '1;
        end else if (wr_en) begin
            ent_q[wr_idx] <= merged;
        end
    end

    assign rd_word = ent_q[rd_idx];

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_word == '1));

    p_clear_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !wr_en);

endmodule

// File: rtl/pmt_array.sv
module pmt_array #(
    parameter int WORDS  = 2048,
    parameter int WORD_W = 24,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wmask,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rq
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            if (erase) mem[widx] <= '1;
            else       mem[widx] <= mem[widx] & wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rq <= '0;
        else if (re) rq <= mem[ridx];
    end

endmodule

// File: rtl/pmt_seq.sv
module pmt_seq
    import pmt_pkg::*;
#(
    parameter int OP_CYCLES  = 520,
    parameter int ROW_WORDS  = 64,
    parameter int PAGE_WORDS = 512,
    parameter int IDX_W      = 11,
    localparam int RIDX_W    = $clog2(ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_row,
    input  logic              start_word,
    input  logic              start_erase,
    input  logic [IDX_W-1:0]  base_idx,
    output logic              busy,
    output logic              done,
    output logic              mem_we,
    output logic              mem_erase,
    output logic [IDX_W-1:0]  mem_widx,
    output logic [RIDX_W-1:0] lat_idx,
    output logic              lat_clear
);
    localparam int CNT_W  = $clog2(OP_CYCLES + 1);
    localparam int PIDX_W = $clog2(PAGE_WORDS);
    localparam logic [IDX_W-1:0] ROW_MASK  = IDX_W'(ROW_WORDS - 1);
    localparam logic [IDX_W-1:0] PAGE_MASK = IDX_W'(PAGE_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(OP_CYCLES - 1);

    pmt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] tgt_q;
    logic             done_q;
    logic             last;

    assign last = (cnt_q == LAST_CNT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_row)        state_d = ST_ROW_PROG;
                else if (start_word)  state_d = ST_WORD_PROG;
                else if (start_erase) state_d = ST_PAGE_ERASE;
            end
            ST_ROW_PROG:   if (last) state_d = ST_IDLE;
            ST_WORD_PROG:  if (last) state_d = ST_IDLE;
            ST_PAGE_ERASE: if (last) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && last;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                tgt_q <= base_idx;
            end else if (!last) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_erase = 1'b0;
        mem_widx  = tgt_q;
        lat_idx   = RIDX_W'(tgt_q);
        lat_clear = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ROW_PROG: begin
                mem_we    = (cnt_q < CNT_W'(ROW_WORDS));
                mem_widx  = (tgt_q & ~ROW_MASK) | IDX_W'(cnt_q[RIDX_W-1:0]);
                lat_idx   = cnt_q[RIDX_W-1:0];
                lat_clear = last;
            end
            ST_WORD_PROG: begin
                mem_we    = (cnt_q == '0);
                lat_clear = last;
            end
            ST_PAGE_ERASE: begin
                mem_we    = (cnt_q < CNT_W'(PAGE_WORDS));
                mem_erase = 1'b1;
                mem_widx  = (tgt_q & ~PAGE_MASK) | IDX_W'(cnt_q[PIDX_W-1:0]);
            end
            default: busy = 1'b0;
        endcase
    end

    assign done = done_q;

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LAST_CNT));

endmodule

// File: rtl/pm_table_unit.sv
module pm_table_unit
    import pmt_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int EA_W       = 16,
    parameter int MEM_WORDS  = 2048,
    parameter int ROW_WORDS  = 64,
    parameter int PAGE_WORDS = 512,
    parameter int OP_CYCLES  = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              byte_mode,
    input  logic [PAGE_W-1:0] page,
    input  logic [EA_W-1:0]   ea,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W  = $clog2(MEM_WORDS);
    localparam int RIDX_W = $clog2(ROW_WORDS);

    pmt_op_e                 op;
    logic [IDX_W-1:0]        idx;
    logic                    lane, cfg_space;
    logic                    free, acc, rd_fire, lat_we;
    logic                    start_row, start_word, start_erase;
    logic                    mem_we, mem_erase, lat_clear;
    logic [IDX_W-1:0]        mem_widx;
    logic [RIDX_W-1:0]       lat_idx;
    logic [PMT_WORD_W-1:0]   lat_word, rq;
    logic                    f_hi_q, f_byte_q, f_lane_q, f_zero_q;

    assign op = pmt_op_e'(cmd_op);

    pmt_addr_gen #(.PAGE_W(PAGE_W), .EA_W(EA_W), .IDX_W(IDX_W)) u_addr (
        .page(page), .ea(ea), .idx(idx), .lane(lane), .cfg_space(cfg_space)
    );

    assign free        = cmd_valid && !busy;
    assign acc         = free && !cfg_space;
    assign rd_fire     = free && (op == OP_RD_LO || op == OP_RD_HI);
    assign lat_we      = acc && (op == OP_WR_LO || op == OP_WR_HI);
    assign start_row   = acc && (op == OP_PROG_ROW);
    assign start_word  = acc && (op == OP_PROG_WORD);
    assign start_erase = acc && (op == OP_ERASE);

    pmt_seq #(
        .OP_CYCLES(OP_CYCLES), .ROW_WORDS(ROW_WORDS),
        .PAGE_WORDS(PAGE_WORDS), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_row(start_row), .start_word(start_word), .start_erase(start_erase),
        .base_idx(idx), .busy(busy), .done(done),
        .mem_we(mem_we), .mem_erase(mem_erase), .mem_widx(mem_widx),
        .lat_idx(lat_idx), .lat_clear(lat_clear)
    );

    pmt_row_latch #(.ROW_WORDS(ROW_WORDS), .WORD_W(PMT_WORD_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(lat_we), .wr_hi(op == OP_WR_HI),
        .byte_mode(byte_mode), .lane(lane), .wr_idx(idx[RIDX_W-1:0]),
        .wdata(wdata), .clear(lat_clear), .rd_idx(lat_idx), .rd_word(lat_word)
    );

    pmt_array #(.WORDS(MEM_WORDS), .WORD_W(PMT_WORD_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .erase(mem_erase),
        .widx(mem_widx), .wmask(lat_word),
        .re(rd_fire && !cfg_space), .ridx(idx), .rq(rq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_hi_q   <= 1'b0;
            f_byte_q <= 1'b0;
            f_lane_q <= 1'b0;
            f_zero_q <= 1'b0;
        end else if (rd_fire) begin
            f_hi_q   <= (op == OP_RD_HI);
            f_byte_q <= byte_mode;
            f_lane_q <= lane;
            f_zero_q <= cfg_space;
        end
    end

    always_comb begin
        if (f_zero_q) begin
            rdata = '0;
        end else if (!f_hi_q) begin
            if (f_byte_q) rdata = {8'h00, f_lane_q ? rq[15:8] : rq[7:0]};
            else          rdata = rq[15:0];
        end else begin
            rdata = (f_byte_q && f_lane_q) ? 16'h0000 : {8'h00, rq[23:16]};
        end
    end

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> $stable(rdata));

    p_cfg_no_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && page[PAGE_W-1]) |=> !busy);

    p_hi_lane1_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd2 && byte_mode && ea[0]) |=> (rdata == 16'h0000));

    p_write_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

endmodule

// File: tb/pm_table_unit_bench.sv
module pm_table_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 2048;
    localparam int ROW_WORDS  = 64;
    localparam int PAGE_WORDS = 512;
    localparam int OP_CYCLES  = 520;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        byte_mode = 1'b0;
    logic [7:0]  page = 8'h00;
    logic [15:0] ea = 16'h0000;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        busy, done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_table_unit #(
        .MEM_WORDS(MEM_WORDS), .ROW_WORDS(ROW_WORDS),
        .PAGE_WORDS(PAGE_WORDS), .OP_CYCLES(OP_CYCLES)
    ) u_pm_table_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .byte_mode(byte_mode), .page(page), .ea(ea), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done)
    );

    // behavioural reference model
    logic [23:0] mmem [MEM_WORDS];
    logic [23:0] mlat [ROW_WORDS];
    int          mstate = 0;
    int          mcnt = 0;
    bit          mdone = 0;
    logic [15:0] mrd = 16'h0;

    function automatic int widx(logic [7:0] pg, logic [15:0] e);
        int full = {pg, e};
        return (full >> 1) % MEM_WORDS;
    endfunction

    function automatic logic [15:0] fmt(logic [23:0] w, bit hi, bit bm, bit ln);
        if (!hi) return bm ? {8'h00, (ln ? w[15:8] : w[7:0])} : w[15:0];
        return (bm && ln) ? 16'h0000 : {8'h00, w[23:16]};
    endfunction

    task automatic model_edge();
        int ix, rb, pb;
        bit cfg;
        if (!rst_n) begin
            mstate = 0; mcnt = 0; mdone = 0; mrd = 16'h0;
            foreach (mlat[i]) mlat[i] = 24'hFFFFFF;
            return;
        end
        mdone = 0;
        if (mstate != 0) begin
            if (mcnt == OP_CYCLES - 1) begin
                if (mstate != 3) foreach (mlat[i]) mlat[i] = 24'hFFFFFF;
                mstate = 0; mdone = 1; mcnt = 0;
            end else mcnt++;
            return;
        end
        if (!cmd_valid) return;
        ix  = widx(page, ea);
        cfg = page[7];
        rb  = ix - (ix % ROW_WORDS);
        pb  = ix - (ix % PAGE_WORDS);
        case (cmd_op)
            3'd1, 3'd2: mrd = cfg ? 16'h0 : fmt(mmem[ix], cmd_op == 3'd2, byte_mode, ea[0]);
            3'd3: if (!cfg) begin
                if (!byte_mode)  mlat[ix % ROW_WORDS][15:0] = wdata;
                else if (!ea[0]) mlat[ix % ROW_WORDS][7:0]  = wdata[7:0];
                else             mlat[ix % ROW_WORDS][15:8] = wdata[7:0];
            end
            3'd4: if (!cfg && (!byte_mode || !ea[0])) mlat[ix % ROW_WORDS][23:16] = wdata[7:0];
            3'd5: if (!cfg) begin
                for (int i = 0; i < ROW_WORDS; i++) mmem[rb + i] = mmem[rb + i] & mlat[i];
                mstate = 1; mcnt = 0;
            end
            3'd6: if (!cfg) begin
                mmem[ix] = mmem[ix] & mlat[ix % ROW_WORDS];
                mstate = 2; mcnt = 0;
            end
            3'd7: if (!cfg) begin
                for (int i = 0; i < PAGE_WORDS; i++) mmem[pb + i] = 24'hFFFFFF;
                mstate = 3; mcnt = 0;
            end
            default: ;
        endcase
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R9 busy per cycle", busy, (mstate != 0));
        chk("R9 done per cycle", done, mdone);
        chk("R2/R3/R4 rdata per cycle", rdata, mrd);
    endtask

    task automatic issue(logic [2:0] o, bit bm, logic [7:0] pg, logic [15:0] e, logic [15:0] wd);
        cmd_valid = 1'b1; cmd_op = o; byte_mode = bm; page = pg; ea = e; wdata = wd;
        step();
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic run_op(logic [2:0] o, logic [7:0] pg, logic [15:0] e);
        int n;
        issue(o, 1'b0, pg, e, 16'h0);
        n = busy ? 1 : 0;
        while (busy && n < OP_CYCLES + 10) begin
            step();
            if (busy) n++;
        end
        chk("R9 busy length", n, OP_CYCLES);
        chk("R9 done after busy", done, 1);
    endtask

    task automatic rd(logic [2:0] o, bit bm, logic [7:0] pg, logic [15:0] e, logic [15:0] exp, string tag);
        issue(o, bm, pg, e, 16'h0);
        chk(tag, rdata, exp);
    endtask

    initial begin
        foreach (mmem[i]) mmem[i] = 24'h0;
        foreach (mlat[i]) mlat[i] = 24'hFFFFFF;
        repeat (3) step();
        chk("R13 reset busy", busy, 0);
        chk("R13 reset done", done, 0);
        chk("R13 reset rdata", rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        step();

        // R8: erase every page first
        for (int p = 0; p < MEM_WORDS / PAGE_WORDS; p++) run_op(3'd7, 8'h00, 16'(p * PAGE_WORDS * 2));
        rd(3'd1, 0, 8'h00, 16'h0010, 16'hFFFF, "R8 erased low");
        rd(3'd2, 0, 8'h00, 16'h0C02, 16'h00FF, "R8 erased high");

        // R5: latch fills, array untouched
        issue(3'd3, 0, 8'h00, 16'h0000, 16'hA5C3);
        issue(3'd4, 0, 8'h00, 16'h0000, 16'h1177);
        issue(3'd3, 1, 8'h00, 16'h0002, 16'h0012);
        issue(3'd3, 1, 8'h00, 16'h0003, 16'h0034);
        issue(3'd4, 1, 8'h00, 16'h0002, 16'h009C);
        issue(3'd4, 1, 8'h00, 16'h0003, 16'h0000);
        rd(3'd1, 0, 8'h00, 16'h0000, 16'hFFFF, "R5 array unchanged before commit");

        // R6: row commit via an address inside row 0
        run_op(3'd5, 8'h00, 16'h0040);
        rd(3'd1, 0, 8'h00, 16'h0000, 16'hA5C3, "R6/R2 low word after row commit");
        rd(3'd2, 0, 8'h00, 16'h0000, 16'h0077, "R4 high word");
        rd(3'd1, 1, 8'h00, 16'h0003, 16'h0034, "R3 low byte lane1");
        rd(3'd1, 1, 8'h00, 16'h0002, 16'h0012, "R3 low byte lane0");
        rd(3'd2, 1, 8'h00, 16'h0002, 16'h009C, "R4 high byte lane0");
        rd(3'd2, 1, 8'h00, 16'h0003, 16'h0000, "R4 high byte lane1 zero");
        rd(3'd2, 0, 8'h00, 16'h0002, 16'h009C, "R5 high lane1 write ignored");
        rd(3'd1, 0, 8'h00, 16'h0004, 16'hFFFF, "R6 unwritten entry stays ones");

        // R12: latch back to ones after commit
        run_op(3'd6, 8'h00, 16'h0000);
        rd(3'd1, 0, 8'h00, 16'h0000, 16'hA5C3, "R12 latch cleared after commit");

        // R7: word commit touches one word
        issue(3'd3, 0, 8'h00, 16'h0086, 16'h1234);
        issue(3'd3, 0, 8'h00, 16'h0088, 16'h0F0F);
        run_op(3'd6, 8'h00, 16'h0086);
        rd(3'd1, 0, 8'h00, 16'h0086, 16'h1234, "R7 addressed word");
        rd(3'd1, 0, 8'h00, 16'h0088, 16'hFFFF, "R7 neighbour unchanged");
        run_op(3'd6, 8'h00, 16'h0088);
        rd(3'd1, 0, 8'h00, 16'h0088, 16'hFFFF, "R12 other entry cleared too");

        // R6: programming only clears bits
        issue(3'd3, 0, 8'h00, 16'h0086, 16'hFF00);
        run_op(3'd6, 8'h00, 16'h0086);
        rd(3'd1, 0, 8'h00, 16'h0086, 16'h1200, "R6 AND merge");

        // a word on page 1 for R8 and R1
        issue(3'd3, 0, 8'h00, 16'h0400, 16'h5555);
        run_op(3'd6, 8'h00, 16'h0400);

        // R10: commands during busy ignored
        rd(3'd1, 0, 8'h00, 16'h0086, 16'h1200, "R10 setup read");
        issue(3'd7, 0, 8'h00, 16'h0080, 16'h0);
        issue(3'd1, 0, 8'h00, 16'h0400, 16'h0);
        issue(3'd3, 0, 8'h00, 16'h008A, 16'h0000);
        issue(3'd5, 0, 8'h00, 16'h0400, 16'h0);
        while (busy) step();
        chk("R10 rdata held", rdata, 16'h1200);
        run_op(3'd6, 8'h00, 16'h008A);
        rd(3'd1, 0, 8'h00, 16'h008A, 16'hFFFF, "R10 latch write refused");
        rd(3'd1, 0, 8'h00, 16'h0086, 16'hFFFF, "R8 page erased");
        rd(3'd1, 0, 8'h00, 16'h0400, 16'h5555, "R8 other page kept");

        // R11: configuration space
        issue(3'd7, 0, 8'h80, 16'h0000, 16'h0);
        chk("R11 erase ignored no busy", busy, 0);
        rd(3'd1, 0, 8'h80, 16'h0400, 16'h0000, "R11 read zero");
        issue(3'd3, 0, 8'h80, 16'h0400, 16'h0000);
        run_op(3'd6, 8'h00, 16'h0400);
        rd(3'd1, 0, 8'h00, 16'h0400, 16'h5555, "R11 write ignored");

        // R1: aliasing above the index bits
        rd(3'd1, 0, 8'h01, 16'h0400, 16'h5555, "R1 page bits above index");
        rd(3'd1, 0, 8'h00, 16'h1400, 16'h5555, "R1 ea bits above index");
        rd(3'd1, 0, 8'h00, 16'h0401, 16'h5555, "R1 byte bit ignored in word mode");

        step();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule